// File: doc/BRIEF.md
# Per-Bank DRAM Timing Tracker

The block sits next to the command issuer of a four-bank DRAM. It watches every command the issuer sends: a one-cycle strobe with an opcode, a bank number, an auto-precharge bit and a burst-length code. For each bank it keeps an open/closed state and a set of countdown timers. From these it produces per-bank ready flags for activate, read, write and precharge, and a device-wide ready flag for refresh. Every spacing limit is a parameter counted in clock cycles.

The block also runs an interval counter that raises a refresh-due request. It does not block anything. A command issued while its ready flag is low sets a sticky violation output, and the command's effect on the bank state is still recorded. The issuer uses the flags to decide what it may send in a given cycle. A bench or monitor uses the violation output to catch a schedule that breaks a rule.

All ready flags are registered. A flag that is high in a cycle means that a command of that type issued in that same cycle is legal.

Top module: `dram_bank_timer`

## Requirements
- R1: Read, write and precharge are ready only for an open bank, and activate is ready only for a closed bank. Activate opens a bank. Precharge closes it.
- R2: A read to a bank becomes ready TRCDRD cycles (default 5) after the activate of that bank, and a write becomes ready TRCDWR cycles (default 3) after it.
- R3: Within one bank, activate needs TRC cycles (default 16) after the previous activate. Precharge needs TRAS cycles (default 11) after activate. Activate needs TRP cycles (default 5) after precharge.
- R4: An activate to any bank needs TRRD cycles (default 3) after the most recent activate to any bank.
- R5: The burst code on `cmd_bl` selects the last write data cycle as the command cycle plus H, where code 0 gives H=1, code 1 gives H=2, and codes 2 and 3 give H=4. After a write, precharge of that bank waits H+TWR cycles (default TWR=4), and a read to any bank waits H+TCDLR cycles (default TCDLR=3). A read does not delay a following read, so reads may be issued on consecutive cycles.
- R6: A read or write with `cmd_autopre`=1 closes its bank at once. The next activate of that bank waits H+TRP cycles after a read, or H+TDAL cycles (default TDAL=9) after a write.
- R7: Refresh is ready only when all banks are closed and every bank's activate timer has expired. After a refresh, activate and refresh both wait TRFC cycles (default 17).
- R8: `ref_due` rises REF_INTERVAL cycles after reset, or after the last refresh, and stays high until a refresh is issued. A refresh issued in the cycle the interval expires wins, so `ref_due` stays low.
- R9: A command with `cmd_valid`=1 whose ready flag is low in that cycle sets `violation` from the next cycle, and `violation` stays set until reset. The command's effect on the bank state is still applied.
- R10: Opcodes on `cmd_op` are 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. Codes 6 and 7 are ignored. After synchronous reset, all banks are closed, `act_ok` and `ref_ok` are all ones, and the other flags, `ref_due` and `violation` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_bank | input | 2 | Target bank |
| cmd_autopre | input | 1 | Auto-precharge on read or write |
| cmd_bl | input | 2 | Burst-length code |
| act_ok | output | 4 | Activate ready, one bit per bank |
| rd_ok | output | 4 | Read ready, one bit per bank |
| wr_ok | output | 4 | Write ready, one bit per bank |
| pre_ok | output | 4 | Precharge ready, one bit per bank |
| ref_ok | output | 1 | Refresh ready |
| ref_due | output | 1 | Refresh requested by the interval counter |
| violation | output | 1 | Sticky illegal-command flag |
| bank_open | output | 4 | Open state of each bank |

## Verification
Two events can fall in the same cycle: the refresh interval expiring and a refresh command clearing the request. The bench closes every bank and waits until refresh is ready. It then issues the refresh exactly in the cycle the interval counter wraps, and checks that `ref_due` stays low and the next interval restarts from that refresh. A behavioural model keeps the earliest legal cycle for every command and bank. Its flags are compared on every clock, through directed sequences, through a long legal-only stream drawn from a pseudo-random generator, and through a deliberate back-to-back activate that must set `violation`.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } dbt_op_e;

  // cycles from the write command to its last data beat
  function automatic logic [2:0] burst_half(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbt_bank.sv
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int CW     = 8,
  parameter int TRC    = 16,
  parameter int TRAS   = 11,
  parameter int TRP    = 5,
  parameter int TRCDRD = 5,
  parameter int TRCDWR = 3,
  parameter int TWR    = 4,
  parameter int TDAL   = 9,
  parameter int TRFC   = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [2:0] op,
  input  logic       autopre,
  input  logic [2:0] half,
  input  logic       ref_cmd,
  output logic       open_n,
  output logic       act_free_n,
  output logic       rd_free_n,
  output logic       wr_free_n,
  output logic       pre_free_n
);
  logic          open_q;
  logic [CW-1:0] act_q, rd_q, wr_q, pre_q;
  logic [CW-1:0] act_n, rd_n, wr_n, pre_n;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // later of the running wait and a new limit of v+1 cycles
  function automatic logic [CW-1:0] ld(input logic [CW-1:0] c, input int v);
    logic [CW-1:0] d;
    d = dec(c);
    return (CW'(v) > d) ? CW'(v) : d;
  endfunction

  always_comb begin
    open_n = open_q;
    act_n  = dec(act_q);
    rd_n   = dec(rd_q);
    wr_n   = dec(wr_q);
    pre_n  = dec(pre_q);
    if (ref_cmd) begin
      act_n = ld(act_q, TRFC - 1);
    end else if (hit) begin
      case (op)
        OP_ACT: begin
          open_n = 1'b1;
          act_n  = ld(act_q, TRC - 1);
          rd_n   = ld(rd_q, TRCDRD - 1);
          wr_n   = ld(wr_q, TRCDWR - 1);
          pre_n  = ld(pre_q, TRAS - 1);
        end
        OP_RD: begin
          if (autopre) begin
            open_n = 1'b0;
            act_n  = ld(act_q, int'(half) + TRP - 1);
          end
        end
        OP_WR: begin
          pre_n = ld(pre_q, int'(half) + TWR - 1);
          if (autopre) begin
            open_n = 1'b0;
            act_n  = ld(act_q, int'(half) + TDAL - 1);
          end
        end
        OP_PRE: begin
          open_n = 1'b0;
          act_n  = ld(act_q, TRP - 1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      act_q  <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      pre_q  <= '0;
    end else begin
      open_q <= open_n;
      act_q  <= act_n;
      rd_q   <= rd_n;
      wr_q   <= wr_n;
      pre_q  <= pre_n;
    end
  end

  assign act_free_n = (act_n == '0);
  assign rd_free_n  = (rd_n == '0);
  assign wr_free_n  = (wr_n == '0);
  assign pre_free_n = (pre_n == '0);
endmodule

// File: rtl/dbt_refresh.sv
module dbt_refresh #(
  parameter int REF_INTERVAL = 2730
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_cmd,
  output logic due
);
  localparam int RW = $clog2(REF_INTERVAL + 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (ref_cmd) begin
      cnt <= '0;
      due <= 1'b0;
    end else if (cnt == RW'(REF_INTERVAL - 1)) begin
      cnt <= '0;
      due <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int TRC          = 16,
  parameter int TRAS         = 11,
  parameter int TRP          = 5,
  parameter int TRCDRD       = 5,
  parameter int TRCDWR       = 3,
  parameter int TRRD         = 3,
  parameter int TWR          = 4,
  parameter int TDAL         = 9,
  parameter int TCDLR        = 3,
  parameter int TRFC         = 17,
  parameter int REF_INTERVAL = 2730,
  localparam int BW          = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [BW-1:0]    cmd_bank,
  input  logic             cmd_autopre,
  input  logic [1:0]       cmd_bl,
  output logic [NBANK-1:0] act_ok,
  output logic [NBANK-1:0] rd_ok,
  output logic [NBANK-1:0] wr_ok,
  output logic [NBANK-1:0] pre_ok,
  output logic             ref_ok,
  output logic             ref_due,
  output logic             violation,
  output logic [NBANK-1:0] bank_open
);
  localparam int CW = $clog2(TRC + TRAS + TRP + TRCDRD + TRCDWR + TRRD +
                             TWR + TDAL + TCDLR + TRFC + 8) + 1;

  logic [2:0]       half;
  logic             ref_cmd;
  logic [NBANK-1:0] open_n, act_free, rd_free, wr_free, pre_free;
  logic [CW-1:0]    rrd_q, rrd_n, cdlr_q, cdlr_n;
  logic             illegal;

  assign half    = burst_half(cmd_bl);
  assign ref_cmd = cmd_valid && (cmd_op == OP_REF);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbt_bank #(
      .CW(CW), .TRC(TRC), .TRAS(TRAS), .TRP(TRP), .TRCDRD(TRCDRD),
      .TRCDWR(TRCDWR), .TWR(TWR), .TDAL(TDAL), .TRFC(TRFC)
    ) u_bank (
      .clk(clk), .rst(rst),
      .hit(cmd_valid && (cmd_bank == BW'(b))),
      .op(cmd_op), .autopre(cmd_autopre), .half(half), .ref_cmd(ref_cmd),
      .open_n(open_n[b]), .act_free_n(act_free[b]), .rd_free_n(rd_free[b]),
      .wr_free_n(wr_free[b]), .pre_free_n(pre_free[b])
    );
  end

  // device-wide spacing: activate to activate, last write data to read
  always_comb begin
    rrd_n  = (rrd_q == '0) ? '0 : rrd_q - 1'b1;
    cdlr_n = (cdlr_q == '0) ? '0 : cdlr_q - 1'b1;
    if (cmd_valid && cmd_op == OP_ACT && CW'(TRRD - 1) > rrd_n)
      rrd_n = CW'(TRRD - 1);
    if (cmd_valid && cmd_op == OP_WR && CW'(int'(half) + TCDLR - 1) > cdlr_n)
      cdlr_n = CW'(int'(half) + TCDLR - 1);
  end

  always_comb begin
    illegal = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_ACT:  illegal = !act_ok[cmd_bank];
        OP_RD:   illegal = !rd_ok[cmd_bank];
        OP_WR:   illegal = !wr_ok[cmd_bank];
        OP_PRE:  illegal = !pre_ok[cmd_bank];
        OP_REF:  illegal = !ref_ok;
        default: illegal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q     <= '0;
      cdlr_q    <= '0;
      act_ok    <= '1;
      rd_ok     <= '0;
      wr_ok     <= '0;
      pre_ok    <= '0;
      ref_ok    <= 1'b1;
      violation <= 1'b0;
      bank_open <= '0;
    end else begin
      rrd_q     <= rrd_n;
      cdlr_q    <= cdlr_n;
      act_ok    <= ~open_n & act_free & {NBANK{rrd_n == '0}};
      rd_ok     <= open_n & rd_free & {NBANK{cdlr_n == '0}};
      wr_ok     <= open_n & wr_free;
      pre_ok    <= open_n & pre_free;
      ref_ok    <= (open_n == '0) && (&act_free);
      violation <= violation | illegal;
      bank_open <= open_n;
    end
  end

  dbt_refresh #(.REF_INTERVAL(REF_INTERVAL)) u_refresh (
    .clk(clk), .rst(rst), .ref_cmd(ref_cmd), .due(ref_due)
  );
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker
  import dbt_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [BW-1:0]    cmd_bank,
  input logic [NBANK-1:0] act_ok,
  input logic [NBANK-1:0] rd_ok,
  input logic [NBANK-1:0] wr_ok,
  input logic [NBANK-1:0] pre_ok,
  input logic             ref_ok,
  input logic             ref_due,
  input logic             violation,
  input logic [NBANK-1:0] bank_open
);
  assert_act_closed_R1: assert property (@(posedge clk) disable iff (rst)
    (act_ok & bank_open) == '0);

  assert_col_open_R1: assert property (@(posedge clk) disable iff (rst)
    ((rd_ok | wr_ok | pre_ok) & ~bank_open) == '0);

  // holds while TRCDRD and TRCDWR are at least 2
  assert_rcd_gap_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT) |=>
      (!rd_ok[$past(cmd_bank)] && !wr_ok[$past(cmd_bank)]));

  // holds while TRRD is at least 2
  assert_rrd_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACT) |=> (act_ok == '0));

  assert_ref_closed_R7: assert property (@(posedge clk) disable iff (rst)
    ref_ok |-> (bank_open == '0));

  assert_ref_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_REF) |=> (act_ok == '0 && !ref_ok));

  assert_ref_clears_due_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_REF) |=> !ref_due);

  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);
endmodule

bind dram_bank_timer dbt_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok),
  .pre_ok(pre_ok), .ref_ok(ref_ok), .ref_due(ref_due),
  .violation(violation), .bank_open(bank_open)
);

// File: tb/tb_dram_bank_timer.sv
module tb_dram_bank_timer;
  localparam int PERIOD = 10;
  localparam int TRC = 16, TRAS = 11, TRP = 5, TRCDRD = 5, TRCDWR = 3;
  localparam int TRRD = 3, TWR = 4, TDAL = 9, TCDLR = 3, TRFC = 17;
  localparam int INTV = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic cmd_autopre = 1'b0;
  logic [1:0] cmd_bl = 2'd0;
  logic [3:0] act_ok, rd_ok, wr_ok, pre_ok, bank_open;
  logic ref_ok, ref_due, violation;

  always #(PERIOD / 2) clk = ~clk;

  dram_bank_timer #(.REF_INTERVAL(INTV)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre), .cmd_bl(cmd_bl),
    .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok),
    .ref_ok(ref_ok), .ref_due(ref_due), .violation(violation),
    .bank_open(bank_open)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model: earliest legal cycle per command, bank state, request, sticky flag
  int k = 0;
  int e_act[4], e_rd[4], e_wr[4], e_pre[4];
  int e_rrd = 0, e_cdlr = 0, rstart = 0;
  bit mopen[4];
  bit mdue = 0, mviol = 0;

  function automatic bit m_act(int b);
    return !mopen[b] && k >= e_act[b] && k >= e_rrd;
  endfunction
  function automatic bit m_rd(int b);
    return mopen[b] && k >= e_rd[b] && k >= e_cdlr;
  endfunction
  function automatic bit m_wr(int b);
    return mopen[b] && k >= e_wr[b];
  endfunction
  function automatic bit m_pre(int b);
    return mopen[b] && k >= e_pre[b];
  endfunction
  function automatic bit m_ref();
    for (int b = 0; b < 4; b++)
      if (mopen[b] || k < e_act[b]) return 1'b0;
    return 1'b1;
  endfunction
  function automatic int mx(int a, int b2);
    return (a > b2) ? a : b2;
  endfunction

  task automatic chk(string what, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", what, k, got, exp);
    end
  endtask

  task automatic compare_all();
    logic [3:0] ea, er, ew, ep, eo;
    for (int b = 0; b < 4; b++) begin
      ea[b] = m_act(b); er[b] = m_rd(b); ew[b] = m_wr(b);
      ep[b] = m_pre(b); eo[b] = mopen[b];
    end
    chk("R1 R3 R4 R6 R7 act_ok", act_ok, ea);
    chk("R1 R2 R5 rd_ok", rd_ok, er);
    chk("R1 R2 wr_ok", wr_ok, ew);
    chk("R1 R3 R5 pre_ok", pre_ok, ep);
    chk("R1 R6 bank_open", bank_open, eo);
    chk("R7 ref_ok", {3'b0, ref_ok}, {3'b0, m_ref()});
    chk("R8 ref_due", {3'b0, ref_due}, {3'b0, mdue});
    chk("R9 violation", {3'b0, violation}, {3'b0, mviol});
  endtask

  task automatic model_apply(bit v, int op, int b, bit ap, int bl);
    int h;
    bit bad;
    h = (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
    bad = 0;
    if (v) begin
      case (op)
        1: bad = !m_act(b);
        2: bad = !m_rd(b);
        3: bad = !m_wr(b);
        4: bad = !m_pre(b);
        5: bad = !m_ref();
        default: bad = 0;
      endcase
    end
    if (bad) mviol = 1;
    if (v && op == 5) begin
      mdue = 0;
      rstart = k + 1;
    end else if (((k - rstart) % INTV) == INTV - 1) begin
      mdue = 1;
    end
    if (v) begin
      case (op)
        1: begin
          mopen[b] = 1;
          e_act[b] = mx(e_act[b], k + TRC);
          e_rd[b]  = mx(e_rd[b], k + TRCDRD);
          e_wr[b]  = mx(e_wr[b], k + TRCDWR);
          e_pre[b] = mx(e_pre[b], k + TRAS);
          e_rrd    = mx(e_rrd, k + TRRD);
        end
        2: if (ap) begin
          mopen[b] = 0;
          e_act[b] = mx(e_act[b], k + h + TRP);
        end
        3: begin
          e_pre[b] = mx(e_pre[b], k + h + TWR);
          e_cdlr   = mx(e_cdlr, k + h + TCDLR);
          if (ap) begin
            mopen[b] = 0;
            e_act[b] = mx(e_act[b], k + h + TDAL);
          end
        end
        4: begin
          mopen[b] = 0;
          e_act[b] = mx(e_act[b], k + TRP);
        end
        5: for (int i = 0; i < 4; i++) e_act[i] = mx(e_act[i], k + TRFC);
        default: ;
      endcase
    end
  endtask

  // one clock cycle: compare, drive, advance the model, move to next cycle
  task automatic cyc(bit v, int op, int b, bit ap, int bl);
    compare_all();
    cmd_valid   = v;
    cmd_op      = 3'(op);
    cmd_bank    = 2'(b);
    cmd_autopre = ap;
    cmd_bl      = 2'(bl);
    model_apply(v, op, b, ap, bl);
    k++;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) begin
      e_act[i] = 0; e_rd[i] = 0; e_wr[i] = 0; e_pre[i] = 0; mopen[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 reset act_ok", act_ok, 4'b1111);
    chk("R10 reset rd/wr/pre", rd_ok | wr_ok | pre_ok | bank_open, 4'b0000);
    chk("R10 reset flags", {1'b0, ref_ok, ref_due, violation}, 4'b0100);
    rst = 0;

    // R2 activate then write at TRCDWR, read after write at H+TCDLR
    cyc(1, 1, 0, 0, 1);
    while (!m_wr(0)) idle();
    cyc(1, 3, 0, 0, 1);
    while (!m_rd(0)) idle();
    // R5 back-to-back reads
    cyc(1, 2, 0, 0, 0);
    cyc(1, 2, 0, 0, 0);
    // R4 activates to other banks at TRRD spacing
    while (!m_act(1)) idle();
    cyc(1, 1, 1, 0, 0);
    while (!m_act(2)) idle();
    cyc(1, 1, 2, 0, 0);
    // R3 R5 precharge after TRAS and write recovery
    while (!m_pre(0)) idle();
    cyc(1, 4, 0, 0, 0);
    // R6 auto-precharge write (burst 8) and read (burst 2)
    while (!m_wr(1)) idle();
    cyc(1, 3, 1, 1, 2);
    while (!m_rd(2)) idle();
    cyc(1, 2, 2, 1, 0);
    while (!m_act(0)) idle();
    cyc(1, 1, 0, 0, 0);
    while (!m_pre(0)) idle();
    cyc(1, 4, 0, 0, 0);
    // R8 refresh in the very cycle the interval expires
    while (!(m_ref() && ((k - rstart) % INTV) == INTV - 1)) idle();
    cyc(1, 5, 0, 0, 0);
    for (int i = 0; i < 3; i++) idle();

    // legal-only pseudo-random stream
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      int op, b;
      bit ok;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = 1 + (int'(lf[2:0]) % 5);
      b  = int'(lf[4:3]);
      case (op)
        1: ok = m_act(b);
        2: ok = m_rd(b);
        3: ok = m_wr(b);
        4: ok = m_pre(b);
        default: ok = m_ref() && mdue;
      endcase
      if (ok && lf[7]) cyc(1, op, b, lf[8] & lf[9], int'(lf[11:10]));
      else idle();
    end

    // R9 illegal back-to-back activate sets the sticky flag
    for (int b = 0; b < 4; b++)
      if (mopen[b]) begin
        while (!m_pre(b)) idle();
        cyc(1, 4, b, 0, 0);
      end
    while (!m_act(0)) idle();
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    // opcode 6 is ignored (R10)
    cyc(1, 6, 3, 0, 0);
    for (int i = 0; i < 30; i++) idle();
    compare_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule